// File: doc/BRIEF.md
# Lock Region Address Encoder

This block turns a range of memory pages into one 64-bit descriptor that names a lock region for an MMU. A caller presents a starting virtual page number and a page count with a one-cycle valid strobe. The block forms the byte address of the first and of the last byte of the range. It then finds the smallest power-of-two region, aligned to its own size, that holds both bytes. The region size comes from the highest bit in which the two addresses differ, so two pages that straddle a large alignment boundary can need a much larger region than their count suggests.

The size is raised to a configured floor. One MMU cache line holds eight table entries, so no region can be smaller than eight pages. Ranges that are empty, or that need a region above a configured ceiling, are rejected. An accepted result is packed as an aligned base in the upper bits and the log2 size minus one in the lowest six bits. Each request gets exactly one answer, a done pulse or an error pulse, a fixed two cycles after its strobe. A new request may be given in every cycle.

Top module: `lock_region_enc`

## Requirements
- R1: The first byte address is `pfn_i << PAGE_SHIFT` and the last byte address is `((pfn_i + count_i) << PAGE_SHIFT) - 1`, both taken modulo 2^64. The region must contain both bytes.
- R2: A request with `count_i == 0` produces an `err_o` pulse and no `done_o` pulse, and `desc_o` keeps its previous value.
- R3: Before clamping, the log2 region size is the 1-based position of the most significant set bit of (first XOR last). For example, page 0x4F with count 2 gives 17.
- R4: If the log2 size before clamping exceeds MAX_LOG2 (default 48), the request produces `err_o` and not `done_o`, and `desc_o` is unchanged. A size of exactly MAX_LOG2 is accepted.
- R5: A log2 size below MIN_LOG2 (default 15) is raised to MIN_LOG2.
- R6: `desc_o[5:0]` holds the final log2 size minus one, so 14 means 32 kB and 47 means 256 TB.
- R7: `desc_o[11:6]` is zero in every result.
- R8: `desc_o[63:12]` holds the first byte address with every bit below the final log2 size cleared.
- R9: A strobe sampled at clock edge n yields exactly one one-cycle pulse on either `done_o` or `err_o` after edge n+2, never both together. `desc_o` changes only together with `done_o` and holds its value otherwise.
- R10: Requests on consecutive cycles are each answered, in order, with no gap in acceptance.
- R11: While `rst_ni` is low, `desc_o` is zero and `done_o` and `err_o` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request strobe, one request per cycle |
| pfn_i | input | PFN_W (52) | Starting virtual page number |
| count_i | input | CNT_W (52) | Number of pages in the range |
| desc_o | output | 64 | Lock-region descriptor, held between results |
| done_o | output | 1 | One-cycle pulse: new descriptor on `desc_o` |
| err_o | output | 1 | One-cycle pulse: request rejected |

## Verification
The hardest case to reach is the edge of the ceiling. A range must be shaped so that the differing-bit position lands on exactly MAX_LOG2, and then on one bit more. This needs page counts near 2^36, which random small counts never produce. The stimulus therefore drives directed ranges from page zero with counts of 2^36 and 2^36+1. It also drives a short range that crosses a high alignment boundary, which forces a very large region from only two pages. Error requests are placed between good ones in a back-to-back burst. This shows that the held descriptor survives a rejection and that the answers stay in order.

// File: rtl/lre_pkg.sv
package lre_pkg;
  localparam int ADDR_W = 64;
  localparam int LOG_W  = $clog2(ADDR_W + 1);

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [LOG_W-1:0]  log_t;

  typedef struct packed {
    logic  vld;
    logic  empty;
    addr_t first;
    addr_t last;
  } span_t;
endpackage

// File: rtl/lre_span.sv
module lre_span
  import lre_pkg::*;
#(
  parameter int PFN_W      = 52,
  parameter int CNT_W      = 52,
  parameter int PAGE_SHIFT = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [PFN_W-1:0] pfn_i,
  input  logic [CNT_W-1:0] count_i,
  output span_t            span_o
);
  addr_t first_d, last_d;

  always_comb begin
    first_d = addr_t'(pfn_i) << PAGE_SHIFT;
    last_d  = ((addr_t'(pfn_i) + addr_t'(count_i)) << PAGE_SHIFT) - addr_t'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      span_o <= '0;
    end else begin
      span_o.vld   <= valid_i;
      span_o.empty <= (count_i == '0);
      if (valid_i) begin
        span_o.first <= first_d;
        span_o.last  <= last_d;
      end
    end
  end
endmodule

// File: rtl/lre_msb.sv
module lre_msb #(
  parameter int W     = 64,
  parameter int OUT_W = $clog2(W + 1)
) (
  input  logic [W-1:0]     vec_i,
  output logic [OUT_W-1:0] pos_o
);
  // 1-based index of the highest set bit, 0 when vec_i is zero
  always_comb begin
    pos_o = '0;
    for (int i = 0; i < W; i++) begin
      if (vec_i[i]) pos_o = OUT_W'(i + 1);
    end
  end
endmodule

// File: rtl/lre_pack.sv
module lre_pack
  import lre_pkg::*;
#(
  parameter int MIN_LOG2 = 15,
  parameter int MAX_LOG2 = 48
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  span_t span_i,
  input  log_t  pos_i,
  output addr_t desc_o,
  output logic  done_o,
  output logic  err_o
);
  localparam log_t MIN_L = log_t'(MIN_LOG2);
  localparam log_t MAX_L = log_t'(MAX_LOG2);
  localparam addr_t RSV_MASK = addr_t'(12'hFC0);

  log_t  size_l;
  logic  reject;
  addr_t align_mask, desc_d;

  always_comb begin
    reject     = span_i.empty || (pos_i > MAX_L);
    size_l     = (pos_i < MIN_L) ? MIN_L : pos_i;
    align_mask = ~((addr_t'(1) << size_l) - addr_t'(1));
    desc_d     = (span_i.first & align_mask & ~RSV_MASK) & ~addr_t'(6'h3F);
    desc_d[5:0] = 6'(size_l - log_t'(1));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      desc_o <= '0;
      done_o <= 1'b0;
      err_o  <= 1'b0;
    end else begin
      done_o <= span_i.vld && !reject;
      err_o  <= span_i.vld && reject;
      if (span_i.vld && !reject) desc_o <= desc_d;
    end
  end
endmodule

// File: rtl/lock_region_enc.sv
module lock_region_enc
  import lre_pkg::*;
#(
  parameter int PFN_W      = 52,
  parameter int CNT_W      = 52,
  parameter int PAGE_SHIFT = 12,
  parameter int MIN_LOG2   = 15,
  parameter int MAX_LOG2   = 48
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [PFN_W-1:0] pfn_i,
  input  logic [CNT_W-1:0] count_i,
  output logic [63:0]      desc_o,
  output logic             done_o,
  output logic             err_o
);
  span_t span_q;
  log_t  msb_pos;
  addr_t diff;

  lre_span #(
    .PFN_W     (PFN_W),
    .CNT_W     (CNT_W),
    .PAGE_SHIFT(PAGE_SHIFT)
  ) i_span (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(valid_i),
    .pfn_i  (pfn_i),
    .count_i(count_i),
    .span_o (span_q)
  );

  assign diff = span_q.first ^ span_q.last;

  lre_msb #(
    .W    (ADDR_W),
    .OUT_W(LOG_W)
  ) i_msb (
    .vec_i(diff),
    .pos_o(msb_pos)
  );

  lre_pack #(
    .MIN_LOG2(MIN_LOG2),
    .MAX_LOG2(MAX_LOG2)
  ) i_pack (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .span_i(span_q),
    .pos_i (msb_pos),
    .desc_o(desc_o),
    .done_o(done_o),
    .err_o (err_o)
  );
endmodule

// File: rtl/lock_region_enc_chk.sv
module lock_region_enc_chk #(
  parameter int PFN_W    = 52,
  parameter int CNT_W    = 52,
  parameter int MIN_LOG2 = 15,
  parameter int MAX_LOG2 = 48
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             valid_i,
  input logic [PFN_W-1:0] pfn_i,
  input logic [CNT_W-1:0] count_i,
  input logic [63:0]      desc_o,
  input logic             done_o,
  input logic             err_o
);
  logic [63:0] low_mask;
  assign low_mask = ((64'd1 << (desc_o[5:0] + 6'd1)) - 64'd1) & ~64'hFFF;

  assert_one_answer_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && err_o));

  assert_latency_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o || err_o) |-> $past(valid_i, 2));

  assert_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(desc_o));

  assert_empty_err_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && count_i == '0) |-> ##2 (err_o && !done_o));

  assert_reserved_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> desc_o[11:6] == 6'd0);

  assert_size_range_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (desc_o[5:0] >= 6'(MIN_LOG2 - 1)) && (desc_o[5:0] <= 6'(MAX_LOG2 - 1)));

  assert_base_aligned_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (desc_o & low_mask) == 64'd0);
endmodule

bind lock_region_enc lock_region_enc_chk #(
  .PFN_W   (PFN_W),
  .CNT_W   (CNT_W),
  .MIN_LOG2(MIN_LOG2),
  .MAX_LOG2(MAX_LOG2)
) i_lock_region_enc_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .valid_i(valid_i),
  .pfn_i  (pfn_i),
  .count_i(count_i),
  .desc_o (desc_o),
  .done_o (done_o),
  .err_o  (err_o)
);

// File: tb/test_lock_region_enc.sv
`timescale 1ns/1ps
module test_lock_region_enc;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [51:0] pfn_i = '0;
  logic [51:0] count_i = '0;
  logic [63:0] desc_o;
  logic        done_o, err_o;

  typedef struct {
    logic [63:0] d;
    bit          e;
    int          cyc;
    string       tag;
  } item_t;

  item_t       sb[$];
  int          n_chk = 0;
  int          n_bad = 0;
  int          cyc = 0;
  logic [63:0] last_good = '0;

  always #2.5 clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  lock_region_enc i_lock_region_enc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(valid_i),
    .pfn_i  (pfn_i),
    .count_i(count_i),
    .desc_o (desc_o),
    .done_o (done_o),
    .err_o  (err_o)
  );

  function automatic void model(input logic [51:0] p, input logic [51:0] c,
                                output bit e, output logic [63:0] d);
    logic [63:0] s, t, x;
    int l = 0;
    s = {p, 12'h000};
    t = {p + c, 12'h000} - 64'd1;
    x = s ^ t;
    for (int i = 0; i < 64; i++) if (x[i]) l = i + 1;
    e = (c == 0) || (l > 48);
    if (l < 15) l = 15;
    d = (s >> l) << l;
    d[5:0] = 6'(l - 1);
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [51:0] p, input logic [51:0] c, input string tag);
    item_t it;
    model(p, c, it.e, it.d);
    it.cyc = cyc + 2;
    it.tag = tag;
    sb.push_back(it);
    pfn_i   = p;
    count_i = c;
    valid_i = 1'b1;
    @(negedge clk_i);
    valid_i = 1'b0;
  endtask

  // monitor
  always @(negedge clk_i) begin
    if (rst_ni && (done_o || err_o)) begin
      if (sb.size() == 0) begin
        check(1'b0, "R9 unexpected pulse", {62'd0, done_o, err_o}, 64'd0);
      end else begin
        item_t it;
        it = sb.pop_front();
        check(!(done_o && err_o), {it.tag, " R9 both pulses"}, {62'd0, done_o, err_o}, 64'd0);
        check(cyc == it.cyc, {it.tag, " R9 latency"}, 64'(cyc), 64'(it.cyc));
        check(err_o == it.e, {it.tag, " R2/R4 error flag"}, {63'd0, err_o}, {63'd0, it.e});
        if (it.e) begin
          check(desc_o == last_good, {it.tag, " R2 desc held on reject"}, desc_o, last_good);
        end else begin
          check(desc_o == it.d, it.tag, desc_o, it.d);
          last_good = it.d;
        end
      end
    end
  end

  initial begin
    #(5.0 * 100000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check(desc_o == 64'd0 && !done_o && !err_o, "R11 reset state",
          {desc_o[61:0], done_o, err_o}, 64'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R3/R1: straddling range, expect 0x40010
    send(52'h4F, 52'd2, "R3 R1 straddle 0x4F+2");
    // R5: tiny range clamped to 32 kB
    send(52'h10, 52'd1, "R5 clamp aligned");
    send(52'h13, 52'd1, "R5 R8 clamp unaligned");
    // R2: empty range
    send(52'h123, 52'd0, "R2 empty count");
    // R4 boundary: exactly 2^48 and one page more
    send(52'h0, 52'h10_0000_0000, "R4 R6 size at ceiling");
    send(52'h0, 52'h10_0000_0001, "R4 above ceiling");
    // two pages across a high boundary
    send(52'h7_FFFF_FFFF, 52'd2, "R3 R8 high straddle");
    repeat (3) @(negedge clk_i);

    // R10: back-to-back burst mixing rejects
    pfn_i = '0;
    for (int k = 0; k < 24; k++) begin
      logic [51:0] p, c;
      p = 52'({$urandom, $urandom});
      p = p & ((52'd1 << (4 + k)) - 52'd1);
      c = 52'($urandom_range(0, 300));
      if (k % 7 == 3) c = 52'd0;
      send(p, c, "R10 R7 R8 burst");
    end
    repeat (4) @(negedge clk_i);
    check(sb.size() == 0, "R9 all answered", 64'(sb.size()), 64'd0);
    check(desc_o[11:6] == 6'd0, "R7 reserved bits", 64'(desc_o[11:6]), 64'd0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule